// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block moves one frame of serial data over the four SPI pins, as either the clocking master or a selected slave. A six-bit control word picks the role, the frame length (8 or 16 bits), whether a low level on the select pin counts as a mode fault, single-wire bidirectional operation, the direction of that single wire, and whether the serial clock freezes while the wait input is high. Every pin has its own input, output and output-enable signal, so the block sits in front of ordinary pad cells.

As master, a write to the data register starts a frame. The engine makes the serial clock from a fixed divider, idles low, samples on the rising edge, shifts on the falling edge, and sends the most significant bit first. As slave, the engine synchronizes the incoming clock, select and data, and it shifts while the select pin is low. In both roles a one-cycle completion pulse marks the end of a frame, and the received word appears at the same time. A master frame is dropped, and the engine goes back to idle, when the role, the frame length, the fault enable, the bidirectional enable, or (in bidirectional mode) the wire direction is rewritten to a new value.

The controller has five states. IDLE moves to M_LEAD on a data write in master role, or to S_SEL when the engine is a slave and the select pin is low. M_LEAD and M_LOW move to M_HIGH on a divider tick. M_HIGH moves to M_LOW on a tick, or to IDLE after the last bit. S_SEL moves to IDLE when select rises or the role changes. A mode fault or a configuration abort forces IDLE from any state.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, busy, done, mode_fault, is_master, sck_o, rx_data, sck_oe and ss_oe are all 0.
- R2: Control word bit 0 selects master role and bit 1 selects 16-bit frames. A master 8-bit frame makes exactly 8 rising edges on sck_o, sends tx_data[7:0] MSB first, and sets rx_data to the 8 received bits with the upper byte zero. The same cycle carries a single-cycle done pulse.
- R3: A master 16-bit frame makes exactly 16 rising edges and sends and receives all 16 bits MSB first.
- R4: Bit 3 is the bidirectional enable. With it clear, a master drives mosi (mosi_oe=1), keeps miso_oe=0 and receives from miso_i.
- R5: With bit 3 set, a master receives from mosi_i and ignores miso_i, keeps miso_oe=0, and sets mosi_oe equal to control bit 4.
- R6: With bit 3 clear, a slave receives from mosi_i and drives miso only while ss_i is low. It never drives mosi. rx_data and done behave as for a master.
- R7: With bit 3 set, a slave receives from miso_i and ignores mosi_i. It sets miso_oe to control bit 4 while selected and never drives mosi.
- R8: During a master frame, a write that changes bit 0, 1, 2 or 3 ends the frame. busy drops on the next cycle, sck_o returns low, and no done pulse follows.
- R9: A change of bit 4 during a master frame ends it only while bit 3 is set. Rewriting the current value, or changing bit 4 with bit 3 clear, lets the frame complete.
- R10: Bit 2 is the fault enable. In master role with it set, a low on ss_i sets mode_fault, clears is_master, stops sck_oe and drops the frame. With it clear, ss_i is ignored in master role. Any control write clears mode_fault.
- R11: Bit 5 is stop-in-wait. With it set, sck_o holds its level while wait_in is high, and the frame resumes and completes after wait_in falls. With it clear, wait_in has no effect.
- R12: The select pin is never driven (ss_oe=0) in either role. tx_data writes are ignored while a master frame runs.
- R13: In slave role, a rise of ss_i before the frame ends discards the partial frame with no done pulse. The next frame restarts its bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 6 | Control word: stop-in-wait, bidir direction, bidir enable, fault enable, 16-bit, master (bit 5 down to 0) |
| tx_we | input | 1 | Data register write strobe (starts a master frame) |
| tx_data | input | WIDE_W | Word to send |
| rx_data | output | WIDE_W | Last received word |
| done | output | 1 | One-cycle frame-complete pulse |
| busy | output | 1 | Engine is not idle |
| is_master | output | 1 | Current role is master |
| mode_fault | output | 1 | Sticky mode-fault flag |
| wait_in | input | 1 | System wait indication |
| sck_i | input | 1 | Serial clock pin input |
| sck_o | output | 1 | Serial clock pin output |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out pin input |
| mosi_o | output | 1 | Master-out pin output |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in pin input |
| miso_o | output | 1 | Master-in pin output |
| miso_oe | output | 1 | Master-in output enable |
| ss_i | input | 1 | Slave select pin input |
| ss_o | output | 1 | Slave select pin output (idle high) |
| ss_oe | output | 1 | Slave select output enable (always 0) |

## Verification
Master frames come from a vector table that varies frame length, routing mode and wire direction. In every entry the unused data pin carries the complement of the real one, so a wrong pin choice shows up as inverted receive data. Patterns with a set high byte in 8-bit mode show whether the upper byte leaks onto the wire or into rx_data, and patterns with asymmetric bit strings catch bit-order errors. Slave frames are driven in both routing modes, including a frame cut short by select. Directed runs then toggle each control bit mid-frame, so that aborts can be told apart from the changes that must be tolerated, and they exercise the mode fault and the wait freeze.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    // Control word layout, bit 0 first: master, wide, fault_en, bidir_en, bidir_oe, stop_wait
    typedef struct packed {
        logic stop_wait;
        logic bidir_oe;
        logic bidir_en;
        logic fault_en;
        logic wide;
        logic master;
    } spi_cfg_t;

    localparam int CFG_W = $bits(spi_cfg_t);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_M_LEAD = 3'd1,
        ST_M_HIGH = 3'd2,
        ST_M_LOW  = 3'd3,
        ST_S_SEL  = 3'd4
    } eng_state_t;

    // True when a control write must end a running master frame
    function automatic logic cfg_breaks_frame(spi_cfg_t cur, logic cur_master, spi_cfg_t nxt);
        logic dir_change;
        dir_change = cur.bidir_en && (cur.bidir_oe != nxt.bidir_oe);
        return (nxt.master != cur_master) || (nxt.wide != cur.wide) ||
               (nxt.fault_en != cur.fault_en) || (nxt.bidir_en != cur.bidir_en) || dir_change;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ss_i,
    input  logic din_i,
    output logic ss_s,
    output logic din_s,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] ss_p;
    logic [STAGES-1:0] din_p;
    logic              sck_d;
    logic              sck_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            ss_p  <= '1;
            din_p <= '0;
            sck_d <= 1'b0;
        end else begin
            sck_p <= {sck_p[STAGES-2:0], sck_i};
            ss_p  <= {ss_p[STAGES-2:0], ss_i};
            din_p <= {din_p[STAGES-2:0], din_i};
            sck_d <= sck_s;
        end
    end

    assign sck_s    = sck_p[STAGES-1];
    assign ss_s     = ss_p[STAGES-1];
    assign din_s    = din_p[STAGES-1];
    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stall,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!stall) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    assign tick = run && !stall && (cnt_q == LAST);

endmodule

// File: rtl/spi_pin_router.sv
module spi_pin_router (
    input  logic master,
    input  logic bidir_en,
    input  logic bidir_oe,
    input  logic ss_act,
    input  logic sdo,
    input  logic sck_q,
    input  logic mosi_i,
    input  logic miso_i,
    output logic data_in,
    output logic sck_o,
    output logic sck_oe,
    output logic mosi_o,
    output logic mosi_oe,
    output logic miso_o,
    output logic miso_oe,
    output logic ss_o,
    output logic ss_oe
);
    always_comb begin
        mosi_oe = 1'b0;
        miso_oe = 1'b0;
        if (master) begin
            data_in = bidir_en ? mosi_i : miso_i;
            mosi_oe = bidir_en ? bidir_oe : 1'b1;
        end else begin
            data_in = bidir_en ? miso_i : mosi_i;
            miso_oe = ss_act && (bidir_en ? bidir_oe : 1'b1);
        end
    end

    assign mosi_o = sdo;
    assign miso_o = sdo;
    assign sck_o  = sck_q;
    assign sck_oe = master;
    assign ss_o   = 1'b1;
    assign ss_oe  = 1'b0;

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter int WIDE_W      = 16,
    parameter int NARROW_W    = 8,
    parameter int DIV_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              tx_we,
    input  logic [WIDE_W-1:0] tx_data,
    output logic [WIDE_W-1:0] rx_data,
    output logic              done,
    output logic              busy,
    output logic              is_master,
    output logic              mode_fault,
    input  logic              wait_in,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_i,
    output logic              ss_o,
    output logic              ss_oe
);
    localparam int CNT_W  = $clog2(WIDE_W + 1);
    localparam int FILL_W = WIDE_W - NARROW_W;

    eng_state_t        state_q, state_d;
    spi_cfg_t          cfg_q, cfg_new;
    logic              master_q, fault_q, wide_x_q, sck_q, done_q;
    logic [WIDE_W-1:0] shreg_q, rxsh_q, rx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ss_s, din_s, sck_rise, sck_fall, ss_act;
    logic              tick, run, stall_w, data_in;
    logic              fault_evt, abort_evt, kill, busy_w;

    function automatic logic [CNT_W-1:0] frame_len(input logic wide);
        return wide ? CNT_W'(WIDE_W) : CNT_W'(NARROW_W);
    endfunction

    function automatic logic [WIDE_W-1:0] align_tx(input logic wide, input logic [WIDE_W-1:0] d);
        return wide ? d : {d[NARROW_W-1:0], {FILL_W{1'b0}}};
    endfunction

    function automatic logic [WIDE_W-1:0] fit_rx(input logic wide, input logic [WIDE_W-1:0] r);
        return wide ? r : {{FILL_W{1'b0}}, r[NARROW_W-1:0]};
    endfunction

    assign cfg_new   = spi_cfg_t'(cfg_wdata);
    assign busy_w    = (state_q != ST_IDLE);
    assign ss_act    = !ss_s;
    assign stall_w   = cfg_q.stop_wait && wait_in;
    assign run       = (state_q == ST_M_LEAD) || (state_q == ST_M_HIGH) || (state_q == ST_M_LOW);
    assign fault_evt = master_q && cfg_q.fault_en && !ss_s;
    assign abort_evt = cfg_we && master_q && busy_w && cfg_breaks_frame(cfg_q, master_q, cfg_new);
    assign kill      = fault_evt || abort_evt;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .ss_i     (ss_i),
        .din_i    (data_in),
        .ss_s     (ss_s),
        .din_s    (din_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    spi_clk_div #(.HALF(DIV_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .stall (stall_w),
        .tick  (tick)
    );

    spi_pin_router u_route (
        .master   (master_q),
        .bidir_en (cfg_q.bidir_en),
        .bidir_oe (cfg_q.bidir_oe),
        .ss_act   (ss_act),
        .sdo      (shreg_q[WIDE_W-1]),
        .sck_q    (sck_q),
        .mosi_i   (mosi_i),
        .miso_i   (miso_i),
        .data_in  (data_in),
        .sck_o    (sck_o),
        .sck_oe   (sck_oe),
        .mosi_o   (mosi_o),
        .mosi_oe  (mosi_oe),
        .miso_o   (miso_o),
        .miso_oe  (miso_oe),
        .ss_o     (ss_o),
        .ss_oe    (ss_oe)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (kill) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (master_q && tx_we)      state_d = ST_M_LEAD;
                    else if (!master_q && ss_act) state_d = ST_S_SEL;
                end
                ST_M_LEAD, ST_M_LOW: begin
                    if (tick) state_d = ST_M_HIGH;
                end
                ST_M_HIGH: begin
                    if (tick) state_d = (cnt_q == CNT_W'(1)) ? ST_IDLE : ST_M_LOW;
                end
                ST_S_SEL: begin
                    if (!ss_act || master_q) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            master_q <= 1'b0;
            fault_q  <= 1'b0;
            wide_x_q <= 1'b0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
            shreg_q  <= '0;
            rxsh_q   <= '0;
            rx_q     <= '0;
            cnt_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (cfg_we) begin
                cfg_q    <= cfg_new;
                master_q <= cfg_new.master;
                fault_q  <= 1'b0;
            end
            if (fault_evt) begin
                fault_q  <= 1'b1;
                master_q <= 1'b0;
            end
            if (kill) begin
                sck_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        sck_q <= 1'b0;
                        if (master_q && tx_we) begin
                            shreg_q  <= align_tx(cfg_q.wide, tx_data);
                            cnt_q    <= frame_len(cfg_q.wide);
                            wide_x_q <= cfg_q.wide;
                            rxsh_q   <= '0;
                        end else if (!master_q) begin
                            if (tx_we) shreg_q <= align_tx(cfg_q.wide, tx_data);
                            if (ss_act) begin
                                cnt_q    <= frame_len(cfg_q.wide);
                                wide_x_q <= cfg_q.wide;
                                rxsh_q   <= '0;
                            end
                        end
                    end
                    ST_M_LEAD, ST_M_LOW: begin
                        if (tick) begin
                            sck_q  <= 1'b1;
                            rxsh_q <= {rxsh_q[WIDE_W-2:0], data_in};
                        end
                    end
                    ST_M_HIGH: begin
                        if (tick) begin
                            sck_q <= 1'b0;
                            cnt_q <= cnt_q - CNT_W'(1);
                            if (cnt_q == CNT_W'(1)) begin
                                done_q <= 1'b1;
                                rx_q   <= fit_rx(wide_x_q, rxsh_q);
                            end else begin
                                shreg_q <= shreg_q << 1;
                            end
                        end
                    end
                    ST_S_SEL: begin
                        if (sck_rise) rxsh_q <= {rxsh_q[WIDE_W-2:0], din_s};
                        if (sck_fall) begin
                            shreg_q <= shreg_q << 1;
                            if (cnt_q == CNT_W'(1)) begin
                                done_q <= 1'b1;
                                rx_q   <= fit_rx(wide_x_q, rxsh_q);
                                cnt_q  <= frame_len(wide_x_q);
                            end else begin
                                cnt_q <= cnt_q - CNT_W'(1);
                            end
                        end
                    end
                    default: sck_q <= 1'b0;
                endcase
            end
        end
    end

    assign rx_data    = rx_q;
    assign done       = done_q;
    assign busy       = busy_w;
    assign is_master  = master_q;
    assign mode_fault = fault_q;

endmodule

// File: rtl/spi_eng_checker.sv
module spi_eng_checker
    import spi_eng_pkg::*;
#(
    parameter int CW = CFG_W
) (
    input logic          clk,
    input logic          rst_n,
    input spi_cfg_t      cfg_q,
    input logic          cfg_we,
    input logic [CW-1:0] cfg_wdata,
    input logic          busy,
    input logic          done,
    input logic          is_master,
    input logic          mode_fault,
    input logic          sck_o,
    input logic          mosi_oe,
    input logic          miso_oe,
    input logic          ss_act,
    input logic          stall
);
    // R2: completion is a single-cycle pulse
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: normal master routing
    a_r4_master_route: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !cfg_q.bidir_en) |-> (mosi_oe && !miso_oe));

    // R5: bidirectional master uses only mosi, direction from control bit 4
    a_r5_bidir_master: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && cfg_q.bidir_en) |-> (!miso_oe && (mosi_oe == cfg_q.bidir_oe)));

    // R6: unselected slave leaves miso undriven
    a_r6_slave_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !ss_act) |-> !miso_oe);

    // R7: slave never drives mosi
    a_r7_slave_no_mosi: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !mosi_oe);

    // R8: width change during a master frame drops to idle
    a_r8_width_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && busy && is_master && (cfg_wdata[1] != cfg_q.wide)) |=> !busy);

    // R10: a new fault leaves the engine idle and out of master role
    a_r10_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && !$past(mode_fault)) |-> (!is_master && !busy));

    // R11: frozen serial clock while stalled
    a_r11_wait_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stall) && $past(busy) && $past(is_master) && busy) |-> $stable(sck_o));

endmodule

bind spi_xfer_engine spi_eng_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_q      (cfg_q),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .busy       (busy),
    .done       (done),
    .is_master  (is_master),
    .mode_fault (mode_fault),
    .sck_o      (sck_o),
    .mosi_oe    (mosi_oe),
    .miso_oe    (miso_oe),
    .ss_act     (ss_act),
    .stall      (stall_w)
);

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_xfer_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_wdata = '0;
    logic        tx_we = 1'b0;
    logic [15:0] tx_data = '0;
    logic [15:0] rx_data;
    logic        done, busy, is_master, mode_fault;
    logic        wait_in = 1'b0;
    logic        sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_i = 1'b1;
    logic        sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;

    int          checks = 0;
    int          errors = 0;
    logic        saw_done = 1'b0;
    logic [15:0] cap_rx = '0;
    bit          finished = 0;

    always #2 clk = ~clk;

    spi_xfer_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tx_we(tx_we), .tx_data(tx_data), .rx_data(rx_data), .done(done), .busy(busy),
        .is_master(is_master), .mode_fault(mode_fault), .wait_in(wait_in),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
    );

    // {wide, bidir_en, bidir_oe, tx word, word returned by the far end}
    localparam logic [34:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 16'h00A5, 16'h003C},
        {1'b0, 1'b0, 1'b0, 16'hFF81, 16'h12C3},
        {1'b1, 1'b0, 1'b0, 16'hBEEF, 16'h1234},
        {1'b1, 1'b0, 1'b0, 16'h8001, 16'hFFFE},
        {1'b0, 1'b1, 1'b1, 16'h005A, 16'h0096},
        {1'b1, 1'b1, 1'b0, 16'hC3A5, 16'h0F0F}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) begin
            @(negedge clk);
            if (done === 1'b1) begin
                saw_done = 1'b1;
                cap_rx   = rx_data;
            end
        end
    endtask

    task automatic write_cfg(input logic [5:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic start_tx(input logic [15:0] v);
        tx_data = v;
        tx_we = 1'b1;
        step(1);
        tx_we = 1'b0;
    endtask

    // far-end bit on the line the role uses, complement on the other line
    task automatic drive_bit(input logic b, input logic on_mosi);
        if (on_mosi) begin mosi_i = b; miso_i = ~b; end
        else         begin miso_i = b; mosi_i = ~b; end
    endtask

    task automatic master_xfer(input logic wide, input logic bid, input logic [15:0] tx,
                               input logic [15:0] sw, output logic [15:0] mo, output int rises);
        int   n;
        int   idx;
        int   guard;
        logic prev;
        n = wide ? 16 : 8;
        idx = 0;
        guard = 0;
        mo = '0;
        rises = 0;
        saw_done = 1'b0;
        drive_bit(sw[n-1], bid);
        start_tx(tx);
        prev = sck_o;
        while (!saw_done && guard < 2000) begin
            step(1);
            guard++;
            if (sck_o && !prev) begin
                rises++;
                mo = {mo[14:0], mosi_o};
            end
            if (!sck_o && prev) begin
                idx++;
                if (idx < n) drive_bit(sw[n-1-idx], bid);
            end
            prev = sck_o;
        end
    endtask

    task automatic slave_xfer(input logic wide, input logic bid, input logic [15:0] mw,
                              input int nbits, output logic [15:0] so);
        int n;
        n = wide ? 16 : 8;
        so = '0;
        saw_done = 1'b0;
        ss_i = 1'b0;
        step(6);
        for (int i = 0; i < nbits; i++) begin
            drive_bit(mw[n-1-i], !bid);
            step(6);
            so = {so[14:0], miso_o};
            sck_i = 1'b1;
            step(6);
            sck_i = 1'b0;
        end
        step(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] mo;
        logic [15:0] so;
        logic        held;
        int          rises;

        step(3);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "mode_fault", mode_fault, 0);
        chk("R1", "is_master", is_master, 0);
        chk("R1", "sck_o", sck_o, 0);
        chk("R1", "sck_oe", sck_oe, 0);
        chk("R1", "rx_data", rx_data, 0);
        chk("R12", "ss_oe reset", ss_oe, 0);

        // Table of master frames: R2 R3 R4 R5
        for (int v = 0; v < 6; v++) begin
            logic        w, b, oe;
            logic [15:0] tx, sw;
            int          n;
            {w, b, oe, tx, sw} = VEC[v];
            n = w ? 16 : 8;
            write_cfg({1'b0, oe, b, 1'b0, w, 1'b1});
            step(2);
            chk(b ? "R5" : "R4", "mosi_oe", mosi_oe, b ? oe : 1'b1);
            chk(b ? "R5" : "R4", "miso_oe", miso_oe, 0);
            chk("R12", "ss_oe master", ss_oe, 0);
            master_xfer(w, b, tx, sw, mo, rises);
            chk(w ? "R3" : "R2", "done seen", saw_done, 1);
            chk(w ? "R3" : "R2", "rising edges", rises, n);
            chk(w ? "R3" : "R2", "mosi bits", mo, w ? tx : {8'h00, tx[7:0]});
            chk(b ? "R5" : "R4", "rx_data", cap_rx, w ? sw : {8'h00, sw[7:0]});
            step(1);
            chk("R2", "done one cycle", done, 0);
            chk("R2", "idle after frame", busy, 0);
        end

        // R12: data writes during a master frame are ignored
        write_cfg(6'h01);
        saw_done = 1'b0;
        drive_bit(1'b0, 1'b0);
        start_tx(16'h0081);
        step(10);
        start_tx(16'h00FF);
        step(80);
        chk("R12", "frame completes", saw_done, 1);
        chk("R12", "rx unaffected", cap_rx, 16'h0000);

        // R8: each of role, width, fault enable, bidir enable aborts
        for (int k = 0; k < 4; k++) begin
            logic [5:0] m;
            m = 6'h01 << k;
            write_cfg(6'h01);
            step(2);
            saw_done = 1'b0;
            start_tx(16'h00C3);
            step(10);
            chk("R8", "busy before change", busy, 1);
            write_cfg(6'h01 ^ m);
            chk("R8", "busy after change", busy, 0);
            chk("R8", "sck low after change", sck_o, 0);
            step(80);
            chk("R8", "no done after abort", saw_done, 0);
        end

        // R9: direction bit with bidir clear and same-value rewrite do not abort
        write_cfg(6'h01);
        step(2);
        saw_done = 1'b0;
        start_tx(16'h0055);
        step(10);
        write_cfg(6'h11);
        write_cfg(6'h11);
        chk("R9", "still busy", busy, 1);
        step(80);
        chk("R9", "frame completes", saw_done, 1);
        write_cfg(6'h09);
        step(2);
        saw_done = 1'b0;
        start_tx(16'h0055);
        step(10);
        write_cfg(6'h19);
        chk("R9", "bidir direction abort", busy, 0);
        step(80);
        chk("R9", "no done", saw_done, 0);

        // R11: stop-in-wait freezes the clock
        write_cfg(6'h21);
        step(2);
        saw_done = 1'b0;
        start_tx(16'h00A5);
        step(9);
        wait_in = 1'b1;
        step(1);
        held = sck_o;
        step(30);
        chk("R11", "sck frozen", sck_o, held);
        chk("R11", "busy while frozen", busy, 1);
        chk("R11", "no done while frozen", saw_done, 0);
        wait_in = 1'b0;
        step(100);
        chk("R11", "resumes and completes", saw_done, 1);
        write_cfg(6'h01);
        wait_in = 1'b1;
        master_xfer(1'b0, 1'b0, 16'h0033, 16'h00E7, mo, rises);
        chk("R11", "wait ignored done", saw_done, 1);
        chk("R11", "wait ignored rx", cap_rx, 16'h00E7);
        wait_in = 1'b0;

        // R10: mode fault
        write_cfg(6'h05);
        step(2);
        saw_done = 1'b0;
        start_tx(16'h00F0);
        step(10);
        ss_i = 1'b0;
        step(6);
        chk("R10", "mode_fault", mode_fault, 1);
        chk("R10", "is_master cleared", is_master, 0);
        chk("R10", "sck_oe", sck_oe, 0);
        chk("R10", "sck_o", sck_o, 0);
        chk("R10", "no done", saw_done, 0);
        ss_i = 1'b1;
        step(4);
        write_cfg(6'h01);
        chk("R10", "cleared by write", mode_fault, 0);
        chk("R10", "master again", is_master, 1);
        ss_i = 1'b0;
        master_xfer(1'b0, 1'b0, 16'h0011, 16'h005C, mo, rises);
        chk("R10", "ss ignored without enable", mode_fault, 0);
        chk("R10", "frame ok without enable", cap_rx, 16'h005C);
        ss_i = 1'b1;

        // R6: normal slave, 16-bit
        write_cfg(6'h02);
        step(4);
        start_tx(16'h9A3C);
        chk("R6", "miso idle unselected", miso_oe, 0);
        chk("R12", "ss_oe slave", ss_oe, 0);
        ss_i = 1'b0;
        step(4);
        chk("R6", "miso driven selected", miso_oe, 1);
        chk("R6", "mosi not driven", mosi_oe, 0);
        slave_xfer(1'b1, 1'b0, 16'h5E71, 16, so);
        chk("R6", "done", saw_done, 1);
        chk("R6", "rx_data", cap_rx, 16'h5E71);
        chk("R6", "miso bits", so, 16'h9A3C);
        ss_i = 1'b1;
        step(6);
        chk("R6", "miso released", miso_oe, 0);

        // R7: bidirectional slave, 8-bit, output enabled
        write_cfg(6'h18);
        step(4);
        start_tx(16'hFF6B);
        slave_xfer(1'b0, 1'b1, 16'h00B4, 8, so);
        chk("R7", "miso_oe", miso_oe, 1);
        chk("R7", "mosi_oe", mosi_oe, 0);
        chk("R7", "rx_data", cap_rx, 16'h00B4);
        chk("R7", "miso bits", so, 16'h006B);
        ss_i = 1'b1;
        step(6);
        write_cfg(6'h08);
        ss_i = 1'b0;
        step(6);
        chk("R7", "miso_oe follows bit 4", miso_oe, 0);
        ss_i = 1'b1;
        step(6);

        // R13: partial slave frame is discarded
        write_cfg(6'h00);
        step(4);
        slave_xfer(1'b0, 1'b0, 16'h00FF, 5, so);
        chk("R13", "no done partial", saw_done, 0);
        ss_i = 1'b1;
        step(6);
        slave_xfer(1'b0, 1'b0, 16'h0029, 8, so);
        chk("R13", "restart done", saw_done, 1);
        chk("R13", "restart rx", cap_rx, 16'h0029);
        ss_i = 1'b1;
        step(6);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule